// File: doc/BRIEF.md
# Nibble-Serial Inter-Chip Memory Link (Master Side)

This block is the master end of a narrow link between two chips. It moves a 20-bit address and 32 bits of data. Five address lanes and eight data lanes each carry one 4-bit nibble per transfer. Each nibble passes through a 4-bit shift register that a gated shift clock steps. The block runs on a fast clock `clk`. Internally it derives a half-rate logic enable, so the control state machine moves at half the shift rate. Each shifter resynchronises the gate from the state machine with one register stage in the fast domain. It then emits exactly four one-cycle shift pulses, separated by low cycles.

Two requesters share the link: a bus-interface source and a run-mode source. Each one pulses a read or a write strobe. The block latches the leading edge as a pending request and clears it when the request is granted.

- **Writes**: address and data shift out together. After a setup interval a write strobe rises.
- **Reads**: only the address shifts out, with the read line high. Then a load strobe asks the slave to shift the addressed word back. The slave supplies its own return shift pulses.
- **Bus permit**: a permit input holds bus-source requests pending while it is low, so the run source has the link for time-critical transfers.
- **Routing flag**: bus-source transfers carry a flag in address bit 19.

State machine states and transitions:

| State | What happens | Next state |
|---|---|---|
| S_IDLE | Arbitration | S_WXFER on a granted write, S_RADDR on a granted read |
| S_WXFER | Address and data shift out | S_WSETUP when both shifters finish |
| S_WSETUP | Write setup, WR_SETUP logic cycles | S_WSTB |
| S_WSTB | Write strobe high | S_DONE |
| S_RADDR | Address shifts out, read line high | S_RLOAD when it finishes |
| S_RLOAD | Load strobe high | S_RWAIT |
| S_RWAIT | Wait for four return nibbles | S_DONE once all four arrive |
| S_DONE | Done pulse to the granted source | S_IDLE |

Top module: `nib_link_master`

## Requirements
- R1: During and right after reset, `lnk_wstb`, `lnk_lstb`, `lnk_rdsel`, `lnk_asclk`, `lnk_dsclk`, `bus_done` and `run_done` are all 0.
- R2: Address lane i carries link address bits [4i+3:4i], most significant bit of the nibble first. The bit is valid while that lane group's shift pulse is high, and the address always travels from master to slave.
- R3: Data lane i carries data bits [4i+3:4i], most significant bit first. The master drives the data lanes (`lnk_doe`=1) except while `lnk_rdsel` is high, and the data shift clock stays quiet during reads.
- R4: Every shifted transfer gives exactly four pulses on each active shift clock. Each pulse is one `clk` cycle high and is never followed directly by another high cycle.
- R5: A write shifts address and data together. `lnk_wstb` then rises at least two logic cycles (4 `clk` cycles) after the last data pulse, with no shift pulse while it is high, and the slave sees the written word.
- R6: A read shifts the address with `lnk_rdsel` high and then raises `lnk_lstb` with `lnk_rdsel` still high. The master collects four nibbles on `lnk_rsclk` pulses from `lnk_din`, most significant bit first per lane, and presents the word on `rdata` with the source's done pulse.
- R7: Only the rising edge of `bus_rd`, `bus_wr`, `run_rd` or `run_wr` creates a request. Holding one high yields exactly one transfer and exactly one one-cycle done pulse.
- R8: While `bus_permit` is 0, a pending bus-source request is not served, and run-source requests are still served. Once the permit returns to 1, the pending request is served.
- R9: When both sources are pending and the bus source is permitted, the run-source request is served first.
- R10: For the link address, bus-source writes and bus-source reads with `bus_mem`=0 set bit 19 to 1. Bus-source reads with `bus_mem`=1 set bit 19 to 0. Run-source addresses pass through unchanged in all 20 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (shift-rate) clock |
| rst_n | input | 1 | Active-low reset |
| bus_rd | input | 1 | Bus-source read request (edge) |
| bus_wr | input | 1 | Bus-source write request (edge) |
| bus_mem | input | 1 | Bus read targets remote memory (no routing flag) |
| bus_permit | input | 1 | 1 allows bus-source service |
| bus_addr | input | 19 | Bus-source address, bits 18..0 |
| bus_wdata | input | 32 | Bus-source write data |
| run_rd | input | 1 | Run-source read request (edge) |
| run_wr | input | 1 | Run-source write request (edge) |
| run_addr | input | 20 | Run-source address |
| run_wdata | input | 32 | Run-source write data |
| bus_done | output | 1 | One-cycle completion of a bus-source transfer |
| run_done | output | 1 | One-cycle completion of a run-source transfer |
| rdata | output | 32 | Read result, valid with done |
| lnk_addr | output | 5 | Address lanes |
| lnk_asclk | output | 1 | Address shift pulses |
| lnk_dout | output | 8 | Data lanes, master to slave |
| lnk_doe | output | 1 | Master drives data lanes |
| lnk_dsclk | output | 1 | Data shift pulses, master to slave |
| lnk_din | input | 8 | Data lanes, slave to master |
| lnk_rsclk | input | 1 | Return shift pulses from slave |
| lnk_rdsel | output | 1 | Read line: slave drives data while high |
| lnk_wstb | output | 1 | Write strobe |
| lnk_lstb | output | 1 | Load strobe for read return |

## Verification
Writes and reads are tried with all-zero, all-one, alternating and distinct-nibble words at low, high and flag-bit addresses. A fault in lane order, in nibble bit order or in the pulse count shows up as a wrong word at the slave model or in `rdata`. Bus and run sources are each tried with reads and writes, with and without `bus_mem`, which separates the three routing-flag cases. A held-high request, a permit-low window with a run read slipped in, and simultaneous requests from both sources tell apart edge detection, permit blocking and service order.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int NIB = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WXFER,
        S_WSETUP,
        S_WSTB,
        S_RADDR,
        S_RLOAD,
        S_RWAIT,
        S_DONE
    } nib_state_t;
endpackage

// File: rtl/nib_req_latch.sv
module nib_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_in,
    input  logic wr_in,
    input  logic clr,
    output logic rd_pend,
    output logic wr_pend
);
    logic rd_q, wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            rd_q <= rd_in;
            wr_q <= wr_in;
            // a new edge wins over a clear in the same cycle
            if (rd_in && !rd_q)  rd_pend <= 1'b1;
            else if (clr)        rd_pend <= 1'b0;
            if (wr_in && !wr_q)  wr_pend <= 1'b1;
            else if (clr)        wr_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/nib_shift_tx.sv
module nib_shift_tx #(
    parameter int LANES = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         gate,
    input  logic [LANES*nib_pkg::NIB-1:0] par,
    output logic [LANES-1:0]             ser,
    output logic                         sclk,
    output logic                         fin
);
    localparam int NB = nib_pkg::NIB;

    logic       g1, g2, act;
    logic [2:0] ph;
    logic       start;

    assign start = g1 && !g2;
    assign sclk  = act && !ph[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g1  <= 1'b0;
            g2  <= 1'b0;
            act <= 1'b0;
            ph  <= '0;
            fin <= 1'b0;
        end else begin
            g1 <= gate;
            g2 <= g1;
            if (start) begin
                act <= 1'b1;
                ph  <= '0;
            end else if (act) begin
                ph <= ph + 3'd1;
                if (ph == 3'd7) act <= 1'b0;
            end
            if (!g1)                      fin <= 1'b0;
            else if (act && ph == 3'd7)   fin <= 1'b1;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [NB-1:0] sr;
        always_ff @(posedge clk) begin
            if (!rst_n)                sr <= '0;
            else if (start)            sr <= par[l*NB +: NB];
            else if (act && !ph[0])    sr <= {sr[NB-2:0], 1'b0};
        end
        assign ser[l] = sr[NB-1];
    end
endmodule

// File: rtl/nib_shift_rx.sv
module nib_shift_rx #(
    parameter int LANES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         arm,
    input  logic                         rsclk,
    input  logic [LANES-1:0]             din,
    output logic [LANES*nib_pkg::NIB-1:0] word,
    output logic                         fin
);
    localparam int NB = nib_pkg::NIB;

    logic [2:0] cnt;
    logic       take;

    assign take = arm && rsclk && !fin;

    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            cnt <= '0;
            fin <= 1'b0;
        end else if (take) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd3) fin <= 1'b1;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [NB-1:0] sr;
        always_ff @(posedge clk) begin
            if (!rst_n)     sr <= '0;
            else if (take)  sr <= {sr[NB-2:0], din[l]};
        end
        assign word[l*NB +: NB] = sr;
    end
endmodule

// File: rtl/nib_link_master.sv
module nib_link_master #(
    parameter int A_LANES  = 5,
    parameter int D_LANES  = 8,
    parameter int WR_SETUP = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_rd,
    input  logic                           bus_wr,
    input  logic                           bus_mem,
    input  logic                           bus_permit,
    input  logic [A_LANES*nib_pkg::NIB-2:0] bus_addr,
    input  logic [D_LANES*nib_pkg::NIB-1:0] bus_wdata,
    input  logic                           run_rd,
    input  logic                           run_wr,
    input  logic [A_LANES*nib_pkg::NIB-1:0] run_addr,
    input  logic [D_LANES*nib_pkg::NIB-1:0] run_wdata,
    output logic                           bus_done,
    output logic                           run_done,
    output logic [D_LANES*nib_pkg::NIB-1:0] rdata,
    output logic [A_LANES-1:0]             lnk_addr,
    output logic                           lnk_asclk,
    output logic [D_LANES-1:0]             lnk_dout,
    output logic                           lnk_doe,
    output logic                           lnk_dsclk,
    input  logic [D_LANES-1:0]             lnk_din,
    input  logic                           lnk_rsclk,
    output logic                           lnk_rdsel,
    output logic                           lnk_wstb,
    output logic                           lnk_lstb
);
    import nib_pkg::*;

    localparam int AW  = A_LANES * NIB;
    localparam int DW  = D_LANES * NIB;
    localparam int SCW = $clog2(WR_SETUP + 1);
    localparam logic [SCW-1:0] SETUP_LAST = SCW'(WR_SETUP - 1);

    nib_state_t state, nxt;
    logic slow_en;
    logic bus_rd_p, bus_wr_p, run_rd_p, run_wr_p;
    logic run_any, bus_any, sel_rd, gnt_run, gnt_bus;
    logic cur_run;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata, rx_word;
    logic [SCW-1:0] setup_cnt;
    logic a_gate, d_gate, rx_arm, a_fin, d_fin, r_fin;

    // half-rate logic enable
    always_ff @(posedge clk) begin
        if (!rst_n) slow_en <= 1'b0;
        else        slow_en <= !slow_en;
    end

    nib_req_latch u_bus_req (
        .clk(clk), .rst_n(rst_n), .rd_in(bus_rd), .wr_in(bus_wr),
        .clr(gnt_bus), .rd_pend(bus_rd_p), .wr_pend(bus_wr_p)
    );
    nib_req_latch u_run_req (
        .clk(clk), .rst_n(rst_n), .rd_in(run_rd), .wr_in(run_wr),
        .clr(gnt_run), .rd_pend(run_rd_p), .wr_pend(run_wr_p)
    );

    assign run_any = run_rd_p || run_wr_p;
    assign bus_any = bus_rd_p || bus_wr_p;
    assign sel_rd  = run_any ? run_rd_p : bus_rd_p;
    assign gnt_run = (state == S_IDLE) && slow_en && run_any;
    assign gnt_bus = (state == S_IDLE) && slow_en && !run_any && bus_any && bus_permit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_run   <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (gnt_run) begin
            cur_run   <= 1'b1;
            cur_addr  <= run_addr;
            cur_wdata <= run_wdata;
        end else if (gnt_bus) begin
            cur_run   <= 1'b0;
            cur_addr  <= {!(bus_rd_p && bus_mem), bus_addr};
            cur_wdata <= bus_wdata;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= S_IDLE;
        else if (slow_en) state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       setup_cnt <= '0;
        else if (slow_en) setup_cnt <= (state == S_WSETUP) ? setup_cnt + 1'b1 : '0;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (run_any || (bus_any && bus_permit))
                          nxt = sel_rd ? S_RADDR : S_WXFER;
            S_WXFER:  if (a_fin && d_fin) nxt = S_WSETUP;
            S_WSETUP: if (setup_cnt == SETUP_LAST) nxt = S_WSTB;
            S_WSTB:   nxt = S_DONE;
            S_RADDR:  if (a_fin) nxt = S_RLOAD;
            S_RLOAD:  nxt = S_RWAIT;
            S_RWAIT:  if (r_fin) nxt = S_DONE;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        a_gate    = 1'b0;
        d_gate    = 1'b0;
        rx_arm    = 1'b0;
        lnk_rdsel = 1'b0;
        lnk_wstb  = 1'b0;
        lnk_lstb  = 1'b0;
        lnk_doe   = 1'b1;
        unique case (state)
            S_WXFER: begin a_gate = 1'b1; d_gate = 1'b1; end
            S_WSTB:  lnk_wstb = 1'b1;
            S_RADDR: begin a_gate = 1'b1; lnk_rdsel = 1'b1; lnk_doe = 1'b0; end
            S_RLOAD: begin lnk_lstb = 1'b1; lnk_rdsel = 1'b1; lnk_doe = 1'b0; rx_arm = 1'b1; end
            S_RWAIT: begin lnk_rdsel = 1'b1; lnk_doe = 1'b0; rx_arm = 1'b1; end
            default: ;
        endcase
    end

    assign bus_done = (state == S_DONE) && slow_en && !cur_run;
    assign run_done = (state == S_DONE) && slow_en &&  cur_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                        rdata <= '0;
        else if (state == S_RWAIT && r_fin) rdata <= rx_word;
    end

    nib_shift_tx #(.LANES(A_LANES)) u_atx (
        .clk(clk), .rst_n(rst_n), .gate(a_gate), .par(cur_addr),
        .ser(lnk_addr), .sclk(lnk_asclk), .fin(a_fin)
    );
    nib_shift_tx #(.LANES(D_LANES)) u_dtx (
        .clk(clk), .rst_n(rst_n), .gate(d_gate), .par(cur_wdata),
        .ser(lnk_dout), .sclk(lnk_dsclk), .fin(d_fin)
    );
    nib_shift_rx #(.LANES(D_LANES)) u_drx (
        .clk(clk), .rst_n(rst_n), .arm(rx_arm), .rsclk(lnk_rsclk),
        .din(lnk_din), .word(rx_word), .fin(r_fin)
    );
endmodule

// File: rtl/nib_link_chk.sv
module nib_link_chk (
    input logic clk,
    input logic rst_n,
    input logic lnk_rdsel,
    input logic lnk_doe,
    input logic lnk_wstb,
    input logic lnk_lstb,
    input logic lnk_asclk,
    input logic lnk_dsclk,
    input logic bus_done,
    input logic run_done
);
    AST_ASCLK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_asclk |=> !lnk_asclk); // R4
    AST_DSCLK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_dsclk |=> !lnk_dsclk); // R4
    AST_RDSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_rdsel |-> !lnk_dsclk); // R3
    AST_WSTB_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_wstb |-> !lnk_asclk && !lnk_dsclk && !lnk_rdsel); // R5
    AST_LSTB_READ: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_lstb |-> lnk_rdsel && !lnk_doe); // R6
    AST_BUS_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |=> !bus_done); // R7
    AST_RUN_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !run_done); // R7
endmodule

bind nib_link_master nib_link_chk chk_i (
    .clk(clk), .rst_n(rst_n), .lnk_rdsel(lnk_rdsel), .lnk_doe(lnk_doe),
    .lnk_wstb(lnk_wstb), .lnk_lstb(lnk_lstb), .lnk_asclk(lnk_asclk),
    .lnk_dsclk(lnk_dsclk), .bus_done(bus_done), .run_done(run_done)
);

// File: tb/nib_link_master_tb_top.sv
module nib_link_master_tb_top;
    localparam int AL = 5, DL = 8, AW = 20, DW = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_rd = 0, bus_wr = 0, bus_mem = 0, bus_permit = 1;
    logic [AW-2:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, run_wdata = '0;
    logic run_rd = 0, run_wr = 0;
    logic [AW-1:0] run_addr = '0;
    logic bus_done, run_done, lnk_asclk, lnk_dsclk, lnk_doe, lnk_rdsel, lnk_wstb, lnk_lstb;
    logic [DW-1:0] rdata;
    logic [AL-1:0] lnk_addr;
    logic [DL-1:0] lnk_dout;
    logic [DL-1:0] lnk_din = '0;
    logic lnk_rsclk = 1'b0;

    always #2 clk = ~clk;

    nib_link_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_mem(bus_mem),
        .bus_permit(bus_permit), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .run_rd(run_rd), .run_wr(run_wr), .run_addr(run_addr), .run_wdata(run_wdata),
        .bus_done(bus_done), .run_done(run_done), .rdata(rdata),
        .lnk_addr(lnk_addr), .lnk_asclk(lnk_asclk), .lnk_dout(lnk_dout), .lnk_doe(lnk_doe),
        .lnk_dsclk(lnk_dsclk), .lnk_din(lnk_din), .lnk_rsclk(lnk_rsclk),
        .lnk_rdsel(lnk_rdsel), .lnk_wstb(lnk_wstb), .lnk_lstb(lnk_lstb)
    );

    typedef struct { bit rd; logic [AW-1:0] addr; logic [DW-1:0] data; } lk_t;
    typedef struct { bit run; bit rd; logic [DW-1:0] data; } cp_t;
    lk_t lq[$];
    cp_t cq[$];

    int n_chk = 0, n_err = 0, nlink = 0, ndone = 0;
    logic [DW-1:0] exp_mem [256];
    logic [DW-1:0] smem [256];
    logic [3:0] sa [AL];
    logic [3:0] sd [DL];
    int acnt = 0, dcnt = 0, gap = 0;
    logic wstb_q = 0, lstb_q = 0;
    logic [DW-1:0] ret_word = '0;
    bit ret_go = 0;

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // slave model: capture lanes on shift pulses
    always @(negedge clk) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        lk_t e;
        if (rst_n) begin
            if (lnk_asclk) begin
                for (int l = 0; l < AL; l++) sa[l] = {sa[l][2:0], lnk_addr[l]};
                acnt++;
            end
            if (lnk_dsclk) begin
                for (int l = 0; l < DL; l++) sd[l] = {sd[l][2:0], lnk_dout[l]};
                dcnt++;
                gap = 0;
            end else gap++;
            for (int l = 0; l < AL; l++) a[l*4 +: 4] = sa[l];
            for (int l = 0; l < DL; l++) d[l*4 +: 4] = sd[l];
            if (lnk_wstb && !wstb_q) begin
                nlink++;
                if (lq.size() == 0) chk(0, "R5 unexpected write strobe", 32'(a), 0);
                else begin
                    e = lq.pop_front();
                    chk(!e.rd, "R5 write strobe for a read", 1, 0);
                    chk(a == e.addr, "R2 R10 write address", 32'(a), 32'(e.addr));
                    chk(d == e.data, "R3 R5 write data", d, e.data);
                    chk(acnt == 4, "R4 address pulses on write", 32'(acnt), 4);
                    chk(dcnt == 4, "R4 data pulses on write", 32'(dcnt), 4);
                    chk(gap >= 4, "R5 setup before strobe", 32'(gap), 4);
                    smem[a[7:0]] = d;
                end
                acnt = 0; dcnt = 0;
            end
            if (lnk_lstb && !lstb_q) begin
                nlink++;
                if (lq.size() == 0) chk(0, "R6 unexpected load strobe", 32'(a), 0);
                else begin
                    e = lq.pop_front();
                    chk(e.rd, "R6 load strobe for a write", 0, 1);
                    chk(a == e.addr, "R2 R10 read address", 32'(a), 32'(e.addr));
                    chk(acnt == 4, "R4 address pulses on read", 32'(acnt), 4);
                    chk(dcnt == 0, "R3 data clock quiet on read", 32'(dcnt), 0);
                    chk(lnk_rdsel && !lnk_doe, "R3 R6 read line and drive", {lnk_rdsel, lnk_doe}, 2'b10);
                    ret_word = smem[a[7:0]];
                    ret_go = 1;
                end
                acnt = 0; dcnt = 0;
            end
            wstb_q = lnk_wstb;
            lstb_q = lnk_lstb;
        end
    end

    // slave model: return shifting on its own pulses
    initial begin
        forever begin
            @(negedge clk);
            if (ret_go) begin
                ret_go = 0;
                @(negedge clk);
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    for (int l = 0; l < DL; l++) lnk_din[l] = ret_word[l*4 + 3 - k];
                    lnk_rsclk = 1'b1;
                    @(negedge clk);
                    lnk_rsclk = 1'b0;
                end
            end
        end
    end

    // completion monitor
    always @(negedge clk) begin
        cp_t c;
        if (rst_n && (bus_done || run_done)) begin
            ndone++;
            if (cq.size() == 0) chk(0, "R7 R8 unexpected done", {bus_done, run_done}, 0);
            else begin
                c = cq.pop_front();
                chk(run_done == c.run && bus_done == !c.run, "R9 R8 service source",
                    {bus_done, run_done}, c.run ? 2'b01 : 2'b10);
                if (c.rd) chk(rdata == c.data, "R6 read data", rdata, c.data);
            end
        end
    end

    task automatic push_exp(bit run, bit rd, bit mem, logic [AW-1:0] a, logic [DW-1:0] d);
        lk_t e;
        cp_t c;
        e.rd = rd;
        e.addr = run ? a : {!(rd && mem), a[AW-2:0]};
        e.data = d;
        if (!rd) exp_mem[a[7:0]] = d;
        c.run = run; c.rd = rd; c.data = exp_mem[a[7:0]];
        lq.push_back(e);
        cq.push_back(c);
    endtask

    task automatic wait_idle();
        while (cq.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic req(bit run, bit rd, bit mem, logic [AW-1:0] a, logic [DW-1:0] d);
        push_exp(run, rd, mem, a, d);
        @(negedge clk);
        if (run) begin run_addr = a; run_wdata = d; end
        else begin bus_addr = a[AW-2:0]; bus_wdata = d; bus_mem = mem; end
        @(negedge clk);
        if (run) begin if (rd) run_rd = 1; else run_wr = 1; end
        else begin if (rd) bus_rd = 1; else bus_wr = 1; end
        @(negedge clk);
        run_rd = 0; run_wr = 0; bus_rd = 0; bus_wr = 0;
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n0, d0;
        for (int i = 0; i < 256; i++) begin exp_mem[i] = '0; smem[i] = '0; end
        for (int l = 0; l < AL; l++) sa[l] = '0;
        for (int l = 0; l < DL; l++) sd[l] = '0;
        repeat (4) @(negedge clk);
        chk(!lnk_wstb && !lnk_lstb && !lnk_rdsel, "R1 strobes in reset", {lnk_wstb, lnk_lstb, lnk_rdsel}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!lnk_asclk && !lnk_dsclk, "R1 shift clocks after reset", {lnk_asclk, lnk_dsclk}, 0);
        chk(!bus_done && !run_done, "R1 done after reset", {bus_done, run_done}, 0);
        chk(!lnk_rdsel && !lnk_wstb && !lnk_lstb, "R1 strobes after reset", {lnk_rdsel, lnk_wstb, lnk_lstb}, 0);

        // R5 R6 run source, several patterns
        req(1, 0, 0, 20'h00012, 32'hDEADBEEF);
        req(1, 1, 0, 20'h00012, 0);
        req(1, 0, 0, 20'hFFF21, 32'h00000000);
        req(1, 1, 0, 20'hFFF21, 0);
        req(1, 0, 0, 20'h3C7A5, 32'hFFFFFFFF);
        req(1, 1, 0, 20'h3C7A5, 0);
        req(1, 0, 0, 20'h80056, 32'h12345678);   // R10 run bit 19 passes
        req(1, 1, 0, 20'h80056, 0);
        // R10 bus source flag cases
        req(0, 0, 0, 20'h00034, 32'hA5A5A5A5);
        req(0, 1, 0, 20'h00034, 0);
        req(0, 1, 1, 20'h00034, 0);
        req(0, 0, 1, 20'h7AB99, 32'h5A5AC33C);
        req(0, 1, 1, 20'h7AB99, 0);

        // R7 held request gives one transfer
        n0 = nlink; d0 = ndone;
        push_exp(1, 0, 0, 20'h00077, 32'h0F0F1E2D);
        run_addr = 20'h00077; run_wdata = 32'h0F0F1E2D;
        @(negedge clk); run_wr = 1;
        repeat (150) @(negedge clk);
        run_wr = 0;
        wait_idle();
        chk(nlink - n0 == 1, "R7 one link transfer for held request", 32'(nlink - n0), 1);
        chk(ndone - d0 == 1, "R7 one done for held request", 32'(ndone - d0), 1);

        // R8 permit blocks bus, not run
        bus_permit = 0;
        bus_addr = 19'h00088; bus_wdata = 32'hCAFEF00D; bus_mem = 0;
        n0 = nlink; d0 = ndone;
        @(negedge clk); bus_wr = 1;
        @(negedge clk); bus_wr = 0;
        repeat (300) @(negedge clk);
        chk(nlink == n0, "R8 no bus transfer while permit low", 32'(nlink - n0), 0);
        chk(ndone == d0, "R8 no done while permit low", 32'(ndone - d0), 0);
        req(1, 1, 0, 20'h00012, 0);
        chk(nlink - n0 == 1, "R8 run served while permit low", 32'(nlink - n0), 1);
        push_exp(0, 0, 0, 20'h00088, 32'hCAFEF00D);
        @(negedge clk); bus_permit = 1;
        wait_idle();
        chk(nlink - n0 == 2, "R8 bus served after permit", 32'(nlink - n0), 2);
        req(0, 1, 0, 20'h00088, 0);

        // R9 simultaneous: run first
        bus_addr = 19'h00099; bus_wdata = 32'h11112222; bus_mem = 0;
        run_addr = 20'h000AA; run_wdata = 32'h33334444;
        push_exp(1, 0, 0, 20'h000AA, 32'h33334444);
        push_exp(0, 0, 0, 20'h00099, 32'h11112222);
        @(negedge clk); bus_wr = 1; run_wr = 1;
        @(negedge clk); bus_wr = 0; run_wr = 0;
        wait_idle();
        req(1, 1, 0, 20'h00099, 0);
        req(0, 1, 1, 20'h000AA, 0);

        chk(lq.size() == 0, "R5 R6 link queue drained", 32'(lq.size()), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule